// File: doc/BRIEF.md
# Three-Window Bus Address Decoder

This block connects one bus master to three slave devices over a shared 16-bit address bus and an 8-bit data path. For each valid transfer it compares the address against three fixed, disjoint windows and raises exactly one slave select. It forwards the address, the direction and the write byte to the slave side. On reads it passes the selected slave's byte back to the master.

The top of the map, 0xF000 to 0xFFFF, belongs to no slave. A write into this hole reaches no device. A read from it returns the byte that was last on the data bus, held in a register inside the block. A flag marks every transfer that lands in the hole. The select and read paths are combinational within the transfer cycle. The bus-hold register updates on the clock edge that completes a transfer.

Top module: `bus_window_decoder`

## Requirements
- R1: A valid transfer with an address in 0x0000..0x7FFF raises select bit 0 only.
- R2: A valid transfer with an address in 0x8000..0xBFFF raises select bit 1 only.
- R3: A valid transfer with an address in 0xC000..0xEFFF raises select bit 2 only.
- R4: At most one select bit is high in any cycle. All select bits are low while the valid strobe is low. A write attempted with valid low changes no slave.
- R5: The slave-side address, write strobe and write byte equal the master's address, direction (1 = write) and write byte in the same cycle.
- R6: During a valid read that hits a window, the master read byte equals the selected slave's read byte in the same cycle.
- R7: The unmapped flag is high exactly when a valid transfer addresses 0xF000..0xFFFF. Such a transfer raises no select bit, so a write there leaves every slave unchanged.
- R8: The bus-hold register captures the write byte of every valid write, including writes to the hole. It captures the returned byte of every mapped valid read.
- R9: A valid read from the hole returns the bus-hold value. Outside a mapped read, the master read byte also shows the bus-hold value.
- R10: Reset clears the bus-hold value to 0x00, so a hole read right after reset returns 0x00.
- R11: Cycles with the valid strobe low leave the bus-hold value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_valid | input | 1 | Transfer valid strobe from the master |
| m_write | input | 1 | Direction: 1 write, 0 read |
| m_addr | input | 16 | Transfer address |
| m_wdata | input | 8 | Write byte from the master |
| m_rdata | output | 8 | Read byte returned to the master |
| m_unmapped | output | 1 | Transfer addresses no window |
| s_sel | output | 3 | One select per slave, bit i for slave i |
| s_write | output | 1 | Direction forwarded to slaves |
| s_addr | output | 16 | Address forwarded to slaves |
| s_wdata | output | 8 | Write byte forwarded to slaves |
| s_rdata | input | 24 | Slave read bytes, slave i in bits [8i+7:8i] |

## Verification
A wrong window comparison shows up in the same cycle as a wrong select pattern. It also has a later effect: a stray write lands in the wrong slave and corrupts data, and that only shows when the location is read back. A bus-hold register that updates on the wrong events, or fails to update, shows nothing until the next read from the hole. The stimulus therefore places hole reads right after writes, after mapped reads, after idle cycles and after reset. Write-then-readback pairs across window edges expose stray or missing selects.

// File: rtl/bus_window_decoder.sv
module bus_window_decoder #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-1:0] W0_LO = 16'h0000,
  parameter logic [AW-1:0] W0_HI = 16'h7FFF,
  parameter logic [AW-1:0] W1_LO = 16'h8000,
  parameter logic [AW-1:0] W1_HI = 16'hBFFF,
  parameter logic [AW-1:0] W2_LO = 16'hC000,
  parameter logic [AW-1:0] W2_HI = 16'hEFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             m_valid,
  input  logic             m_write,
  input  logic [AW-1:0]    m_addr,
  input  logic [DW-1:0]    m_wdata,
  output logic [DW-1:0]    m_rdata,
  output logic             m_unmapped,
  output logic [2:0]       s_sel,
  output logic             s_write,
  output logic [AW-1:0]    s_addr,
  output logic [DW-1:0]    s_wdata,
  input  logic [3*DW-1:0]  s_rdata
);
  localparam int NS = 3;
  localparam logic [AW-1:0] LO [NS] = '{W0_LO, W1_LO, W2_LO};
  localparam logic [AW-1:0] HI [NS] = '{W0_HI, W1_HI, W2_HI};

  logic [NS-1:0] hit;
  logic [DW-1:0] slave_byte;
  logic [DW-1:0] bus_hold;
  logic          rd_hit;

  for (genvar i = 0; i < NS; i++) begin : g_win
    logic [AW-1:0] off;
    assign off    = m_addr - LO[i];
    assign hit[i] = off <= (HI[i] - LO[i]);
  end

  assign s_sel      = m_valid ? hit : '0;
  assign m_unmapped = m_valid && (hit == '0);
  assign s_write    = m_write;
  assign s_addr     = m_addr;
  assign s_wdata    = m_wdata;

  always_comb begin
    slave_byte = '0;
    for (int i = 0; i < NS; i++)
      if (hit[i]) slave_byte = s_rdata[i*DW +: DW];
  end

  assign rd_hit  = m_valid && !m_write && (hit != '0);
  assign m_rdata = rd_hit ? slave_byte : bus_hold;

  always_ff @(posedge clk) begin
    if (!rst_n)
      bus_hold <= '0;
    else if (m_valid && m_write)
      bus_hold <= m_wdata;
    else if (rd_hit)
      bus_hold <= slave_byte;
  end

  assert_one_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(s_sel));
  assert_idle_no_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !m_valid |-> s_sel == '0);
  assert_hole_no_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
    m_unmapped |-> s_sel == '0);
  assert_hold_takes_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_write) |=> bus_hold == $past(m_wdata));
  assert_hold_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !m_valid |=> $stable(bus_hold));
  assert_hole_read_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_unmapped && !m_write) |=> $stable(bus_hold));
endmodule

// File: tb/bus_window_decoder_test.sv
module bus_window_decoder_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        m_valid = 0, m_write = 0;
  logic [15:0] m_addr = 0;
  logic [7:0]  m_wdata = 0;
  logic [7:0]  m_rdata;
  logic        m_unmapped;
  logic [2:0]  s_sel;
  logic        s_write;
  logic [15:0] s_addr;
  logic [7:0]  s_wdata;
  logic [23:0] s_rdata;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  bus_window_decoder uut (
    .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_write(m_write),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata),
    .m_unmapped(m_unmapped), .s_sel(s_sel), .s_write(s_write),
    .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata));

  logic [7:0] mem [3][16];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < 3; s++)
        for (int k = 0; k < 16; k++) mem[s][k] <= 8'h00;
    end else begin
      for (int s = 0; s < 3; s++)
        if (s_sel[s] && s_write) mem[s][s_addr[3:0]] <= s_wdata;
    end
  end
  assign s_rdata = {mem[2][s_addr[3:0]], mem[1][s_addr[3:0]], mem[0][s_addr[3:0]]};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic w, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    m_valid = v; m_write = w; m_addr = a; m_wdata = d;
    #2;
  endtask

  function automatic string sel_tag(input logic [2:0] s);
    case (s)
      3'b001: return "R1";
      3'b010: return "R2";
      3'b100: return "R3";
      default: return "R7";
    endcase
  endfunction

  // {write, addr, wdata, expected rdata, expected sel, expected unmapped}
  localparam logic [36:0] VEC [18] = '{
    {1'b1, 16'h3000, 8'hAA, 8'h00, 3'b001, 1'b0},
    {1'b0, 16'h3000, 8'h00, 8'hAA, 3'b001, 1'b0},
    {1'b1, 16'h9001, 8'h55, 8'hAA, 3'b010, 1'b0},
    {1'b0, 16'h9001, 8'h00, 8'h55, 3'b010, 1'b0},
    {1'b1, 16'hC002, 8'h3C, 8'h55, 3'b100, 1'b0},
    {1'b0, 16'hEFF2, 8'h00, 8'h3C, 3'b100, 1'b0},
    {1'b1, 16'hFF00, 8'h99, 8'h3C, 3'b000, 1'b1},
    {1'b0, 16'hFF00, 8'h00, 8'h99, 3'b000, 1'b1},
    {1'b0, 16'h7FFF, 8'h00, 8'h00, 3'b001, 1'b0},
    {1'b0, 16'hF000, 8'h00, 8'h00, 3'b000, 1'b1},
    {1'b0, 16'h3000, 8'h00, 8'hAA, 3'b001, 1'b0},
    {1'b0, 16'hFFFF, 8'h00, 8'hAA, 3'b000, 1'b1},
    {1'b0, 16'hBFFF, 8'h00, 8'h00, 3'b010, 1'b0},
    {1'b0, 16'h8001, 8'h00, 8'h55, 3'b010, 1'b0},
    {1'b0, 16'hF001, 8'h00, 8'h55, 3'b000, 1'b1},
    {1'b0, 16'hC000, 8'h00, 8'h00, 3'b100, 1'b0},
    {1'b0, 16'h8000, 8'h00, 8'h00, 3'b010, 1'b0},
    {1'b0, 16'h0000, 8'h00, 8'hAA, 3'b001, 1'b0}
  };

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    drive(0, 0, 16'h0000, 8'h00);
    rst_n = 1;
    drive(0, 1, 16'h0005, 8'h42);
    check("R4 idle select", s_sel, 3'b000);
    check("R7 idle flag", m_unmapped, 1'b0);
    check("R10 reset hold", m_rdata, 8'h00);
    drive(1, 0, 16'hFFFF, 8'h00);
    check("R10 hole read after reset", m_rdata, 8'h00);
    check("R7 hole flag", m_unmapped, 1'b1);

    for (int i = 0; i < 18; i++) begin
      logic [36:0] v;
      v = VEC[i];
      drive(1, v[36], v[35:20], v[19:12]);
      check($sformatf("%s vec%0d select", sel_tag(v[3:1]), i), s_sel, v[3:1]);
      check($sformatf("R7 vec%0d flag", i), m_unmapped, v[0]);
      check($sformatf("%s vec%0d rdata", v[0] ? "R9" : (v[36] ? "R8" : "R6"), i), m_rdata, v[11:4]);
      check($sformatf("R5 vec%0d fwd", i), {s_write, s_addr, s_wdata}, {v[36], v[35:20], v[19:12]});
    end

    drive(1, 0, 16'h8001, 8'h00);
    drive(0, 1, 16'h0004, 8'h77);
    check("R11 idle shows hold", m_rdata, 8'h55);
    drive(0, 0, 16'h0000, 8'h00);
    drive(1, 0, 16'hF800, 8'h00);
    check("R11 hold kept over idle", m_rdata, 8'h55);
    drive(1, 0, 16'h0004, 8'h00);
    check("R4 idle write dropped", m_rdata, 8'h00);

    drive(1, 1, 16'hF0F1, 8'h5A);
    drive(1, 0, 16'hF123, 8'h00);
    check("R8 hold from hole write", m_rdata, 8'h5A);
    drive(1, 0, 16'h0001, 8'h00);
    check("R7 hole write dropped slave0", m_rdata, 8'h00);
    drive(1, 0, 16'hC001, 8'h00);
    check("R7 hole write dropped slave2", m_rdata, 8'h00);

    drive(1, 1, 16'h1000, 8'hE1);
    @(negedge clk);
    rst_n = 0;
    drive(0, 0, 16'h0000, 8'h00);
    rst_n = 1;
    drive(1, 0, 16'hF000, 8'h00);
    check("R10 hold cleared by reset", m_rdata, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule